// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block owns every refresh-related strobe that an asynchronous DRAM with a row-count refresh requirement needs. After reset it keeps the memory idle for a programmable power-up pause. It then runs a fixed number of wake-up cycles, each a CAS-before-RAS (CBR) strobe pair. When these are done it raises `initDone`, and the access controller may start normal traffic.

From then on a slot timer marks the spacing of distributed refreshes. For each slot the sequencer asks the access controller for the strobe lines with `busReq`. It drives RAS and CAS only while `busGrant` is held. Slots that cannot be served at once are counted and served back-to-back later. If too many slots are lost, the refresh period is treated as broken: the block flags an error and reruns the wake-up cycles. On command it places the memory in self-refresh and takes it out again. On leaving self-refresh it can optionally burst-refresh every row.

All widths and timings are parameters given in clock cycles. CBR refreshes use an internal row counter in the memory, so the block drives no address.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is held and just after it, `rasN` and `casN` are high, and `busReq`, `initDone`, `srActive` and `errFlag` are low.
- R2: `busReq` stays low for at least `PAUSE_CYC` clock cycles after reset is released.
- R3: After the pause exactly `WAKE_CNT` RAS low pulses are issued, and only then does `initDone` rise.
- R4: Every strobe pair meets the following timing:
  - `casN` is low for at least `CAS_LEAD_CYC` cycles before `rasN` falls.
  - `casN` stays low for at least `CAS_HOLD_CYC` cycles after `rasN` falls.
  - `rasN` stays low for at least `RAS_LOW_CYC` cycles.
  - `rasN` stays high for at least `RAS_PRE_CYC` cycles before it falls again.
- R5: `rasN` or `casN` is driven low only while `busGrant` is high. `busReq` stays high from the request until the strobe sequence ends.
- R6: Once `initDone` is high and the grant is given at once, consecutive refresh RAS falls are exactly `SLOT_CYC` cycles apart. The slot timer restarts from zero when normal operation resumes after self-refresh.
- R7: Slots that arrive while the grant is withheld are remembered, up to `PEND_MAX` of them. When the grant returns, one CBR refresh is issued for each stored slot, back-to-back.
- R8: A slot that arrives while `PEND_MAX` slots are already pending has these effects:
  - `errFlag` is set and stays set until reset.
  - The pending slots are discarded and `initDone` falls.
  - `WAKE_CNT` wake-up pulses are issued again before `initDone` rises again.
- R9: A `srEnter` request taken while idle has these effects:
  - It issues a CBR entry and raises `srActive`.
  - `rasN` and `casN` then stay low for at least `SR_MIN_CYC` cycles, even when `srExit` is already high.
- R10: On leaving self-refresh, `rasN` and `casN` stay high for at least `SR_EXIT_CYC` cycles while `srActive` stays high. No slot refresh is issued while `srActive` is high.
- R11: If `burstOnExit` is high when self-refresh ends, exactly `ROW_CNT` CBR pulses are issued before `srActive` falls. If it is low, no pulse is issued before `srActive` falls.
- R12: `srEnter` has no effect before `initDone` first rises: `srActive` stays low and the wake-up count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busGrant | input | 1 | Access controller hands the strobe lines to this block |
| srEnter | input | 1 | Level request to enter self-refresh |
| srExit | input | 1 | Level request to leave self-refresh |
| burstOnExit | input | 1 | Refresh all rows in a burst after self-refresh ends |
| busReq | output | 1 | Request for the strobe lines |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| initDone | output | 1 | Power-up and wake-up are complete; access may start |
| srActive | output | 1 | Self-refresh, its exit window or its exit burst is in progress |
| errFlag | output | 1 | Sticky flag: the pending slot count overflowed |

## Verification
The hardest state to reach is overflow of the pending slot count. It needs `PEND_MAX` slots to build up, and one more to arrive, while the block sits requesting without a grant. The bench reaches it with an arbiter model that holds back the grant for well over `PEND_MAX` slot periods. It then checks that the wake-up cycles are rerun. The catch-up case needs the grant removed for a known number of slots. The bench times that removal from an observed refresh RAS fall, so the number of slots that pile up is known exactly. The self-refresh minimum hold is exercised by raising `srExit` in the same cycle that `srActive` rises.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  typedef enum logic [3:0] {
    S_PAUSE, S_IDLE, S_REQ, S_CASLEAD, S_HOLD, S_RASREST, S_PRECH, S_SRLOW, S_SREXIT
  } rfsh_state_e;

  typedef enum logic [1:0] {
    K_REFRESH, K_WAKE, K_BURST, K_SELF
  } rfsh_kind_e;

  typedef enum logic [2:0] {
    L_CASLEAD, L_CASHOLD, L_RASREST, L_PRECH, L_SRMIN, L_SREXIT
  } rfsh_load_e;

  typedef struct packed {
    logic       load;       // reload the phase counter
    rfsh_load_e sel;        // which length to load
    logic       clrRows;    // restart the wake/burst counter
    logic       incRows;    // one wake/burst pulse finished
    logic       decPend;    // one slot refresh finished
    logic       clrPend;    // drop pending slots and restart the slot timer
    logic       runTimer;   // slot timer may advance
    logic       ackRewake;  // re-wake request taken
  } rfsh_strobe_t;

endpackage

// File: rtl/rfsh_datapath.sv
module rfsh_datapath
  import rfsh_pkg::*;
#(
  parameter int PAUSE_CYC    = 25000,
  parameter int SLOT_CYC     = 1950,
  parameter int RAS_LOW_CYC  = 8,
  parameter int RAS_PRE_CYC  = 5,
  parameter int CAS_LEAD_CYC = 1,
  parameter int CAS_HOLD_CYC = 2,
  parameter int WAKE_CNT     = 8,
  parameter int SR_MIN_CYC   = 12500,
  parameter int SR_EXIT_CYC  = 13,
  parameter int ROW_CNT      = 2048,
  parameter int PEND_MAX     = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  rfsh_strobe_t stb,
  output logic         phaseZero,
  output logic         pendNonZero,
  output logic         wakeDone,
  output logic         burstDone,
  output logic         rewakeReq,
  output logic         errFlag
);

  localparam int MAX_AB = (PAUSE_CYC > SR_MIN_CYC) ? PAUSE_CYC : SR_MIN_CYC;
  localparam int MAXV   = (MAX_AB > SLOT_CYC) ? MAX_AB : SLOT_CYC;
  localparam int CNT_W  = $clog2(MAXV + 1);
  localparam int ROWMAX = (ROW_CNT > WAKE_CNT) ? ROW_CNT : WAKE_CNT;
  localparam int ROWS_W = $clog2(ROWMAX + 1);
  localparam int PEND_W = $clog2(PEND_MAX + 1);

  logic [CNT_W-1:0]  phaseCnt, loadVal;
  logic [CNT_W-1:0]  slotCnt;
  logic [ROWS_W-1:0] rowCnt;
  logic [PEND_W-1:0] pendCnt;
  logic              slotTick, pendFull, pendDec;

  // Phase lengths: the state lasts exactly N cycles after a load of N-1.
  always_comb begin
    case (stb.sel)
      L_CASLEAD: loadVal = CNT_W'(CAS_LEAD_CYC - 1);
      L_CASHOLD: loadVal = CNT_W'(CAS_HOLD_CYC - 1);
      L_RASREST: loadVal = CNT_W'(RAS_LOW_CYC - CAS_HOLD_CYC - 1);
      L_PRECH:   loadVal = CNT_W'(RAS_PRE_CYC - 1);
      L_SRMIN:   loadVal = CNT_W'(SR_MIN_CYC - 1);
      L_SREXIT:  loadVal = CNT_W'(SR_EXIT_CYC - 1);
      default:   loadVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)                phaseCnt <= CNT_W'(PAUSE_CYC - 1);
    else if (stb.load)        phaseCnt <= loadVal;
    else if (phaseCnt != '0)  phaseCnt <= phaseCnt - 1'b1;
  end
  assign phaseZero = (phaseCnt == '0);

  // Slot timer
  assign slotTick = stb.runTimer && (slotCnt == CNT_W'(SLOT_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rstN || !stb.runTimer || stb.clrPend) slotCnt <= '0;
    else if (slotTick)                         slotCnt <= '0;
    else                                       slotCnt <= slotCnt + 1'b1;
  end

  // Pending slots with overflow detection
  assign pendFull = (pendCnt == PEND_W'(PEND_MAX));
  assign pendDec  = stb.decPend && (pendCnt != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendCnt   <= '0;
      rewakeReq <= 1'b0;
      errFlag   <= 1'b0;
    end else begin
      if (stb.ackRewake) rewakeReq <= 1'b0;
      if (stb.clrPend) begin
        pendCnt <= '0;
      end else if (slotTick && pendFull) begin
        pendCnt   <= '0;
        rewakeReq <= 1'b1;
        errFlag   <= 1'b1;
      end else if (slotTick && !pendDec) begin
        pendCnt <= pendCnt + 1'b1;
      end else if (!slotTick && pendDec) begin
        pendCnt <= pendCnt - 1'b1;
      end
    end
  end
  assign pendNonZero = (pendCnt != '0);

  // Wake / burst pulse counter
  always_ff @(posedge clk) begin
    if (!rstN || stb.clrRows) rowCnt <= '0;
    else if (stb.incRows)     rowCnt <= rowCnt + 1'b1;
  end

  generate
    if (WAKE_CNT > 1) begin : g_wake_multi
      assign wakeDone = (rowCnt == ROWS_W'(WAKE_CNT - 1));
    end else begin : g_wake_single
      assign wakeDone = 1'b1;
    end
  endgenerate
  assign burstDone = (rowCnt == ROWS_W'(ROW_CNT - 1));

  p_pend_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    pendCnt <= PEND_W'(PEND_MAX));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  p_overflow_rewake_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> rewakeReq);

endmodule

// File: rtl/rfsh_control.sv
module rfsh_control
  import rfsh_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         busGrant,
  input  logic         srEnter,
  input  logic         srExit,
  input  logic         burstOnExit,
  input  logic         phaseZero,
  input  logic         pendNonZero,
  input  logic         wakeDone,
  input  logic         burstDone,
  input  logic         rewakeReq,
  output rfsh_strobe_t stb,
  output logic         busReq,
  output logic         rasN,
  output logic         casN,
  output logic         initDone,
  output logic         srActive
);

  rfsh_state_e state, stateNext;
  rfsh_kind_e  kind, kindNext;
  logic        initNext;

  always_comb begin
    stateNext = state;
    kindNext  = kind;
    initNext  = initDone;
    stb       = '0;
    stb.sel   = L_CASLEAD;
    stb.runTimer = initDone && (kind == K_REFRESH);

    case (state)
      S_PAUSE: if (phaseZero) begin
        stateNext   = S_REQ;
        kindNext    = K_WAKE;
        stb.clrRows = 1'b1;
      end
      S_IDLE: begin
        if (rewakeReq) begin
          stateNext     = S_REQ;
          kindNext      = K_WAKE;
          initNext      = 1'b0;
          stb.clrRows   = 1'b1;
          stb.ackRewake = 1'b1;
        end else if (pendNonZero) begin
          stateNext = S_REQ;
          kindNext  = K_REFRESH;
        end else if (srEnter) begin
          stateNext = S_REQ;
          kindNext  = K_SELF;
        end
      end
      S_REQ: begin
        if (kind == K_REFRESH && rewakeReq) begin
          kindNext      = K_WAKE;
          initNext      = 1'b0;
          stb.clrRows   = 1'b1;
          stb.ackRewake = 1'b1;
        end else if (busGrant) begin
          stateNext = S_CASLEAD;
          stb.load  = 1'b1;
          stb.sel   = L_CASLEAD;
        end
      end
      S_CASLEAD: if (phaseZero) begin
        stateNext = S_HOLD;
        stb.load  = 1'b1;
        stb.sel   = L_CASHOLD;
      end
      S_HOLD: if (phaseZero) begin
        stb.load = 1'b1;
        if (kind == K_SELF) begin
          stateNext   = S_SRLOW;
          stb.sel     = L_SRMIN;
          stb.clrPend = 1'b1;
        end else begin
          stateNext = S_RASREST;
          stb.sel   = L_RASREST;
        end
      end
      S_RASREST: if (phaseZero) begin
        stateNext = S_PRECH;
        stb.load  = 1'b1;
        stb.sel   = L_PRECH;
      end
      S_PRECH: if (phaseZero) begin
        case (kind)
          K_REFRESH: begin
            stb.decPend = 1'b1;
            if (rewakeReq) begin
              stateNext     = S_REQ;
              kindNext      = K_WAKE;
              initNext      = 1'b0;
              stb.clrRows   = 1'b1;
              stb.ackRewake = 1'b1;
            end else begin
              stateNext = S_IDLE;
            end
          end
          K_WAKE: begin
            if (wakeDone) begin
              stateNext = S_IDLE;
              kindNext  = K_REFRESH;
              initNext  = 1'b1;
            end else begin
              stateNext   = S_REQ;
              stb.incRows = 1'b1;
            end
          end
          K_BURST: begin
            if (burstDone) begin
              stateNext = S_IDLE;
              kindNext  = K_REFRESH;
            end else begin
              stateNext   = S_REQ;
              stb.incRows = 1'b1;
            end
          end
          default: begin
            stateNext = S_IDLE;
            kindNext  = K_REFRESH;
          end
        endcase
      end
      S_SRLOW: if (phaseZero && srExit) begin
        stateNext = S_SREXIT;
        stb.load  = 1'b1;
        stb.sel   = L_SREXIT;
      end
      S_SREXIT: if (phaseZero) begin
        if (burstOnExit) begin
          stateNext   = S_REQ;
          kindNext    = K_BURST;
          stb.clrRows = 1'b1;
        end else begin
          stateNext = S_IDLE;
          kindNext  = K_REFRESH;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_PAUSE;
      kind     <= K_REFRESH;
      initDone <= 1'b0;
    end else begin
      state    <= stateNext;
      kind     <= kindNext;
      initDone <= initNext;
    end
  end

  assign rasN     = !(state == S_HOLD || state == S_RASREST || state == S_SRLOW);
  assign casN     = !(state == S_CASLEAD || state == S_HOLD || state == S_SRLOW);
  assign busReq   = !(state == S_PAUSE || state == S_IDLE);
  assign srActive = (state == S_SRLOW) || (state == S_SREXIT) ||
                    (kind == K_BURST && state != S_IDLE);

  p_cas_leads_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> (!casN && $past(!casN)));

  p_strobe_granted_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!rasN || !casN) |-> busGrant);

  p_ready_after_wake_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(initDone) |-> $past(state == S_PRECH && kind == K_WAKE));

  p_sr_min_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_SRLOW && !phaseZero) |=> (!rasN && !casN));

  p_no_req_in_pause_r2: assert property (@(posedge clk) disable iff (!rstN)
    !initDone && !phaseZero && $stable(initDone) && !busReq |=> !$rose(rasN));

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import rfsh_pkg::*;
#(
  parameter int PAUSE_CYC    = 25000,
  parameter int SLOT_CYC     = 1950,
  parameter int RAS_LOW_CYC  = 8,
  parameter int RAS_PRE_CYC  = 5,
  parameter int CAS_LEAD_CYC = 1,
  parameter int CAS_HOLD_CYC = 2,
  parameter int WAKE_CNT     = 8,
  parameter int SR_MIN_CYC   = 12500,
  parameter int SR_EXIT_CYC  = 13,
  parameter int ROW_CNT      = 2048,
  parameter int PEND_MAX     = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic busGrant,
  input  logic srEnter,
  input  logic srExit,
  input  logic burstOnExit,
  output logic busReq,
  output logic rasN,
  output logic casN,
  output logic initDone,
  output logic srActive,
  output logic errFlag
);

  rfsh_strobe_t stb;
  logic phaseZero, pendNonZero, wakeDone, burstDone, rewakeReq;

  rfsh_control ctrl_i (
    .clk, .rstN, .busGrant, .srEnter, .srExit, .burstOnExit,
    .phaseZero, .pendNonZero, .wakeDone, .burstDone, .rewakeReq,
    .stb, .busReq, .rasN, .casN, .initDone, .srActive
  );

  rfsh_datapath #(
    .PAUSE_CYC(PAUSE_CYC), .SLOT_CYC(SLOT_CYC), .RAS_LOW_CYC(RAS_LOW_CYC),
    .RAS_PRE_CYC(RAS_PRE_CYC), .CAS_LEAD_CYC(CAS_LEAD_CYC), .CAS_HOLD_CYC(CAS_HOLD_CYC),
    .WAKE_CNT(WAKE_CNT), .SR_MIN_CYC(SR_MIN_CYC), .SR_EXIT_CYC(SR_EXIT_CYC),
    .ROW_CNT(ROW_CNT), .PEND_MAX(PEND_MAX)
  ) dp_i (
    .clk, .rstN, .stb, .phaseZero, .pendNonZero, .wakeDone, .burstDone,
    .rewakeReq, .errFlag
  );

endmodule

// File: tb/dram_refresh_sched_tb_top.sv
module dram_refresh_sched_tb_top;

  localparam int PAUSE = 40, SLOT = 40, RLOW = 4, RPRE = 3, CLEAD = 1, CHOLD = 2;
  localparam int WAKE = 8, SRMIN = 50, SREXIT = 6, ROWS = 16, PMAX = 8;

  logic clk = 1'b0, rstN = 1'b0, busGrant = 1'b0;
  logic srEnter = 1'b0, srExit = 1'b0, burstOnExit = 1'b0, allowGrant = 1'b1;
  logic busReq, rasN, casN, initDone, srActive, errFlag;

  int nTests = 0, nFail = 0;
  int cyc = 0, fallCnt = 0, lastFallCyc = 0, lastGap = 0, lastLow = 0, lastHigh = 0;
  int lowRun = 0, highRun = 1000, casLowRun = 0, shapeViol = 0, grantViol = 0;
  logic prevRas = 1'b1, prevCas = 1'b1, srSeen = 1'b0;

  always #4 clk = ~clk;

  dram_refresh_sched #(
    .PAUSE_CYC(PAUSE), .SLOT_CYC(SLOT), .RAS_LOW_CYC(RLOW), .RAS_PRE_CYC(RPRE),
    .CAS_LEAD_CYC(CLEAD), .CAS_HOLD_CYC(CHOLD), .WAKE_CNT(WAKE), .SR_MIN_CYC(SRMIN),
    .SR_EXIT_CYC(SREXIT), .ROW_CNT(ROWS), .PEND_MAX(PMAX)
  ) dut_i (
    .clk, .rstN, .busGrant, .srEnter, .srExit, .burstOnExit,
    .busReq, .rasN, .casN, .initDone, .srActive, .errFlag
  );

  // Arbiter model: grants on request, holds the grant until the request drops.
  always begin
    @(posedge clk); #1;
    busGrant = rstN && busReq && (allowGrant || busGrant);
  end

  // Strobe monitor, sampled on the falling edge.
  always @(negedge clk) begin
    cyc++;
    if (srActive) srSeen = 1'b1;
    if (rstN) begin
      if ((!rasN || !casN) && !busGrant) grantViol++;
      if (prevRas && !rasN) begin
        fallCnt++;
        lastHigh = highRun;
        if (casLowRun < CLEAD) shapeViol++;
        if (highRun < RPRE) shapeViol++;
        lastGap = cyc - lastFallCyc;
        lastFallCyc = cyc;
      end
      if (!prevRas && rasN) begin
        lastLow = lowRun;
        if (lowRun < RLOW) shapeViol++;
      end
      if (!prevCas && casN && !rasN && lowRun < CHOLD) shapeViol++;
    end
    lowRun    = rasN ? 0 : lowRun + 1;
    highRun   = rasN ? highRun + 1 : 0;
    casLowRun = casN ? 0 : casLowRun + 1;
    prevRas = rasN;
    prevCas = casN;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #2; end
  endtask

  task automatic waitFall(input int limit, output bit seen);
    int f0 = fallCnt;
    seen = 1'b0;
    for (int i = 0; i < limit && !seen; i++) begin
      step(1);
      if (fallCnt != f0) seen = 1'b1;
    end
  endtask

  task automatic t_reset;
    step(3);
    check(rasN && casN && !busReq && !initDone && !srActive && !errFlag, "R1 outputs in reset",
          {rasN, casN, busReq, initDone, srActive, errFlag}, 6'b110000);
  endtask

  task automatic t_powerup;
    int n = 0;
    rstN = 1'b1;
    srEnter = 1'b1;                    // R12: must be ignored before init
    step(1);
    check(rasN && casN && !busReq && !initDone, "R1 outputs after release", {rasN, casN, busReq}, 3'b110);
    n = 1;
    while (!busReq && n < PAUSE + 20) begin
      if (n == 10) srEnter = 1'b0;
      step(1); n++;
    end
    srEnter = 1'b0;
    check(n >= PAUSE && n <= PAUSE + 2, "R2 pause length", n, PAUSE);
    for (int i = 0; i < 400 && !initDone; i++) step(1);
    step(1);
    check(initDone == 1'b1, "R3 initDone raised", initDone, 1);
    check(fallCnt == WAKE, "R3 wake-up pulse count", fallCnt, WAKE);
    check(!srSeen, "R12 srEnter ignored before init", srSeen, 0);
  endtask

  task automatic t_slot_spacing;
    bit seen;
    waitFall(100, seen);
    waitFall(100, seen);
    check(seen && lastGap == SLOT, "R6 slot spacing", lastGap, SLOT);
    waitFall(100, seen);
    check(seen && lastGap == SLOT, "R6 slot spacing repeat", lastGap, SLOT);
  endtask

  task automatic t_catchup;
    bit seen;
    int f0;
    waitFall(100, seen);
    allowGrant = 1'b0;
    step(3 * SLOT + 10);
    check(fallCnt == 0 + fallCnt && rasN && casN, "R5 no strobe without grant", grantViol, 0);
    f0 = fallCnt;
    allowGrant = 1'b1;
    step(25);
    check(fallCnt - f0 == 3, "R7 catch-up refresh count", fallCnt - f0, 3);
  endtask

  task automatic t_overflow;
    bit seen;
    int f0;
    waitFall(100, seen);
    step(RLOW + RPRE + 3);
    allowGrant = 1'b0;
    for (int i = 0; i < (PMAX + 4) * SLOT && !errFlag; i++) step(1);
    check(errFlag == 1'b1, "R8 overflow flag", errFlag, 1);
    step(2);
    check(initDone == 1'b0, "R8 initDone dropped", initDone, 0);
    f0 = fallCnt;
    allowGrant = 1'b1;
    for (int i = 0; i < 400 && !initDone; i++) step(1);
    step(1);
    check(initDone && (fallCnt - f0 == WAKE), "R8 wake-up rerun count", fallCnt - f0, WAKE);
    check(errFlag == 1'b1, "R8 flag sticky", errFlag, 1);
  endtask

  task automatic t_selfref(input bit burst);
    bit seen;
    int f0;
    waitFall(100, seen);
    step(RLOW + RPRE + 3);
    burstOnExit = burst;
    srEnter = 1'b1;
    for (int i = 0; i < 100 && !srActive; i++) step(1);
    srEnter = 1'b0;
    srExit = 1'b1;                     // early exit request: minimum hold must win
    f0 = fallCnt;
    check(srActive == 1'b1, "R9 srActive raised", srActive, 1);
    step(SRMIN / 2);
    check(!rasN && !casN, "R9 strobes held low", {rasN, casN}, 0);
    for (int i = 0; i < SRMIN + 20 && !rasN; i++) step(1);
    check(srActive == 1'b1, "R10 srActive through exit window", srActive, 1);
    step(1);
    check(lastLow >= SRMIN, "R9 self-refresh low time", lastLow, SRMIN);
    for (int i = 0; i < 20 * ROWS + 100 && srActive; i++) step(1);
    srExit = 1'b0;
    if (burst) begin
      check(fallCnt - f0 == ROWS, "R11 exit burst pulse count", fallCnt - f0, ROWS);
      check(fallCnt - f0 == ROWS && lastGap > 0, "R10 exit precharge before burst",
            shapeViol, 0);
    end else begin
      check(fallCnt == f0, "R11 no pulse without burst", fallCnt - f0, 0);
      check(highRun >= SREXIT, "R10 exit window high time", highRun, SREXIT);
      f0 = cyc;
      waitFall(SLOT + 10, seen);
      check(seen && (cyc - f0) >= SLOT, "R6 slot timer restarts after exit", cyc - f0, SLOT);
    end
  endtask

  initial begin
    t_reset();
    t_powerup();
    t_slot_spacing();
    t_catchup();
    t_selfref(1'b1);
    t_selfref(1'b0);
    t_overflow();
    check(shapeViol == 0, "R4 strobe timing violations", shapeViol, 0);
    check(grantViol == 0, "R5 strobes outside grant", grantViol, 0);
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #(8 * 50000);
    nTests++;
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule